// File: doc/BRIEF.md
# Colour Attribute Shadow-RAM Controller

This block looks after a 5-bit attribute memory that sits beside the byte-wide program and display memory. Both memories use the same address lines. Each attribute cell holds a 3-bit foreground colour, a reverse-video flag and a graphic/character flag. The block contains a colour register that the processor can reach as an I/O location. Ordinary processor memory cycles to the display window move attribute data through that register. A write stores the register's attribute into the attribute memory. A read loads the cell's attribute into the register, unless the register's hold bit is set.

Each bus cycle is split into two clock periods. In the first period the video side fetches the display byte and its attribute from the same address. In the second period the processor uses the memories. The processor therefore never delays a video fetch. Both memories are external and have an asynchronous read port.

Top module: `attr_shadow_ctrl`

## Requirements
- R1: After reset the colour register is zero (an I/O read returns 0x00), `cpu_slot` is low, `vid_valid` is low and no write strobe is active.
- R2: The slot signal `cpu_slot` alternates every clock, starting low (video) after reset. Processor strobes are acted on only while `cpu_slot` is high. While it is low, `mem_we` and `atr_we` stay low.
- R3: In a video slot both memory addresses follow `vid_addr`. On the edge that closes the slot, the main byte goes to `vid_data` and the attribute goes to `vid_attr`, and `vid_valid` pulses high for one clock.
- R4: A video fetch outside the display window returns the main byte, with `vid_attr` forced to zero.
- R5: A processor memory write inside the window raises `mem_we` and `atr_we` in the same slot. `atr_wdata` then carries the register attribute {graphic, reverse, colour[2:0]}.
- R6: A processor memory read inside the window returns the main byte on `cpu_rdata` after the slot's closing edge. When the hold bit is 0, the same read loads the cell's 5-bit attribute into the register.
- R7: When the hold bit is 1, processor memory reads leave the colour register unchanged.
- R8: The I/O view of the register uses this layout: bits 2:0 colour, bit 3 reverse, bit 4 graphic, bit 7 hold. Bits 6:5 always read as zero. An I/O write loads all of these fields.
- R9: Processor accesses outside the window [WIN_LO, WIN_HI] (default 0x0000 to 0x3FFF) never write the attribute memory and never change the colour register.
- R10: An I/O access raises neither `mem_we` nor `atr_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_io | input | 1 | Selects the colour register instead of memory |
| cpu_rdata | output | 8 | Registered processor read data |
| cpu_slot | output | 1 | High during the processor slot |
| vid_addr | input | 16 | Video fetch address |
| vid_data | output | 8 | Fetched display byte |
| vid_attr | output | 5 | Fetched attribute {graphic, reverse, colour} |
| vid_valid | output | 1 | One-clock pulse when the video outputs update |
| mem_addr | output | 16 | Main memory address |
| mem_wdata | output | 8 | Main memory write data |
| mem_we | output | 1 | Main memory write enable |
| mem_rdata | input | 8 | Main memory read data (asynchronous) |
| atr_addr | output | 14 | Attribute memory address |
| atr_wdata | output | 5 | Attribute memory write data |
| atr_we | output | 1 | Attribute memory write enable |
| atr_rdata | input | 5 | Attribute memory read data (asynchronous) |

## Verification
Write strobes and write data are combinational within a slot. The bench samples them 1 ns after it drives the strobe, before the slot's closing edge. `cpu_rdata` and the colour register update on the edge that closes the processor slot, so their effect is checked at the following falling edge. The video outputs update on the edge that closes the video slot, and the bench checks them, together with the `vid_valid` pulse, one falling edge after it sets `vid_addr`. Effects on the register are observed through later I/O reads, and effects on the attribute memory through later memory reads.

// File: rtl/attr_pkg.sv
package attr_pkg;

    localparam int DATA_W = 8;
    localparam int ATTR_W = 5;

    typedef enum logic {
        SLOT_VIDEO = 1'b0,
        SLOT_CPU   = 1'b1
    } slot_e;

    typedef struct packed {
        logic       hold;
        logic       graphic;
        logic       reverse;
        logic [2:0] colour;
    } creg_t;

    function automatic logic [ATTR_W-1:0] attr_of(input creg_t c);
        return {c.graphic, c.reverse, c.colour};
    endfunction

    function automatic logic [DATA_W-1:0] io_view(input creg_t c);
        return {c.hold, 2'b00, c.graphic, c.reverse, c.colour};
    endfunction

    function automatic creg_t io_load(input logic [DATA_W-1:0] d);
        creg_t c;
        c.hold    = d[7];
        c.graphic = d[4];
        c.reverse = d[3];
        c.colour  = d[2:0];
        return c;
    endfunction

    function automatic logic in_window(input int unsigned a, input int unsigned lo,
                                       input int unsigned hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/attr_slot_seq.sv
module attr_slot_seq
    import attr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output slot_e slot
);
    always_ff @(posedge clk) begin
        if (rst) slot <= SLOT_VIDEO;
        else     slot <= (slot == SLOT_VIDEO) ? SLOT_CPU : SLOT_VIDEO;
    end

    // R2: the slots strictly alternate
    a_r2_alternate: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> slot != $past(slot));
endmodule

// File: rtl/attr_color_reg.sv
module attr_color_reg
    import attr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  creg_t             io_data,
    input  logic              ld,
    input  logic [ATTR_W-1:0] ld_attr,
    output creg_t             creg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            creg <= '0;
        end else if (io_wr) begin
            creg <= io_data;
        end else if (ld && !creg.hold) begin
            creg.graphic <= ld_attr[4];
            creg.reverse <= ld_attr[3];
            creg.colour  <= ld_attr[2:0];
        end
    end

    // R6: an unheld read takes the cell's attribute and keeps the hold bit
    a_r6_load: assert property (@(posedge clk) disable iff (rst)
        (ld && !creg.hold && !io_wr) |=>
            (attr_of(creg) == $past(ld_attr)) && !creg.hold);

    // R7: a held register does not move on reads
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (ld && creg.hold && !io_wr) |=> $stable(creg));
endmodule

// File: rtl/attr_video_latch.sv
module attr_video_latch
    import attr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch,
    input  logic              in_win,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [ATTR_W-1:0] atr_rdata,
    output logic [DATA_W-1:0] vid_data,
    output logic [ATTR_W-1:0] vid_attr,
    output logic              vid_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vid_data  <= '0;
            vid_attr  <= '0;
            vid_valid <= 1'b0;
        end else begin
            vid_valid <= fetch;
            if (fetch) begin
                vid_data <= mem_rdata;
                vid_attr <= in_win ? atr_rdata : '0;
            end
        end
    end

    // R3: one update pulse per video slot
    a_r3_pulse: assert property (@(posedge clk) disable iff (rst)
        vid_valid |=> !vid_valid);

    // R4: fetches outside the window carry no attribute
    a_r4_attr_zero: assert property (@(posedge clk) disable iff (rst)
        (fetch && !in_win) |=> (vid_attr == '0));
endmodule

// File: rtl/attr_shadow_ctrl.sv
module attr_shadow_ctrl
    import attr_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int ATTR_AW = 14,
    parameter int WIN_LO  = 32'h0000,
    parameter int WIN_HI  = 32'h3FFF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic               cpu_io,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cpu_slot,
    input  logic [ADDR_W-1:0]  vid_addr,
    output logic [DATA_W-1:0]  vid_data,
    output logic [ATTR_W-1:0]  vid_attr,
    output logic               vid_valid,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               mem_we,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [ATTR_AW-1:0] atr_addr,
    output logic [ATTR_W-1:0]  atr_wdata,
    output logic               atr_we,
    input  logic [ATTR_W-1:0]  atr_rdata
);
    slot_e slot;
    creg_t creg;
    logic  cpu_win, vid_win;
    logic  op_io_rd, op_io_wr, op_mem_rd, op_mem_wr;
    logic  unused_bits;

    attr_slot_seq u_seq (.clk(clk), .rst(rst), .slot(slot));

    assign cpu_slot  = (slot == SLOT_CPU);
    assign cpu_win   = in_window(32'(cpu_addr), WIN_LO, WIN_HI);
    assign vid_win   = in_window(32'(vid_addr), WIN_LO, WIN_HI);

    assign op_io_rd  = cpu_slot &  cpu_io & cpu_rd;
    assign op_io_wr  = cpu_slot &  cpu_io & cpu_wr;
    assign op_mem_rd = cpu_slot & ~cpu_io & cpu_rd;
    assign op_mem_wr = cpu_slot & ~cpu_io & cpu_wr;

    assign mem_addr  = cpu_slot ? cpu_addr : vid_addr;
    assign mem_wdata = cpu_wdata;
    assign mem_we    = op_mem_wr;
    assign atr_addr  = mem_addr[ATTR_AW-1:0];
    assign atr_wdata = attr_of(creg);
    assign atr_we    = op_mem_wr & cpu_win;
    assign unused_bits = ^cpu_wdata[6:5];

    attr_color_reg u_creg (
        .clk(clk), .rst(rst),
        .io_wr(op_io_wr), .io_data(io_load(cpu_wdata)),
        .ld(op_mem_rd & cpu_win), .ld_attr(atr_rdata),
        .creg(creg)
    );

    attr_video_latch u_vid (
        .clk(clk), .rst(rst),
        .fetch(!cpu_slot), .in_win(vid_win),
        .mem_rdata(mem_rdata), .atr_rdata(atr_rdata),
        .vid_data(vid_data), .vid_attr(vid_attr), .vid_valid(vid_valid)
    );

    always_ff @(posedge clk) begin
        if (rst)            cpu_rdata <= '0;
        else if (op_io_rd)  cpu_rdata <= io_view(creg);
        else if (op_mem_rd) cpu_rdata <= mem_rdata;
    end

    // R2: no writes in the video slot
    a_r2_video_quiet: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_VIDEO) |-> (!mem_we && !atr_we));

    // R9: attribute writes only inside the window
    a_r9_outside: assert property (@(posedge clk) disable iff (rst)
        atr_we |-> in_window(32'(cpu_addr), WIN_LO, WIN_HI));

    // R10: register accesses leave both memories alone
    a_r10_io_quiet: assert property (@(posedge clk) disable iff (rst)
        cpu_io |-> (!mem_we && !atr_we));

    // R5: attribute write travels with the main write
    a_r5_paired: assert property (@(posedge clk) disable iff (rst)
        atr_we |-> (mem_we && mem_addr[ATTR_AW-1:0] == atr_addr));
endmodule

// File: tb/tb_attr_shadow_ctrl.sv
module tb_attr_shadow_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0, vid_addr = '0, mem_addr;
    logic [7:0]  cpu_wdata = '0, cpu_rdata, vid_data, mem_wdata, mem_rdata;
    logic        cpu_rd = 0, cpu_wr = 0, cpu_io = 0;
    logic        cpu_slot, vid_valid, mem_we, atr_we;
    logic [4:0]  vid_attr, atr_wdata, atr_rdata;
    logic [13:0] atr_addr;

    logic [7:0] mmem [256];
    logic [4:0] amem [256];

    int tests = 0, fails = 0;
    logic done = 1'b0;
    logic s_mem_we, s_atr_we;
    logic [4:0] s_atr_wdata;

    always #2.5 clk = ~clk;

    attr_shadow_ctrl dut (.*);

    assign mem_rdata = mmem[mem_addr[7:0]];
    assign atr_rdata = amem[atr_addr[7:0]];
    always @(posedge clk) begin
        if (mem_we) mmem[mem_addr[7:0]] <= mem_wdata;
        if (atr_we) amem[atr_addr[7:0]] <= atr_wdata;
    end

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic [7:0]  exp;
        logic [3:0]  rq;
    } vec_t;
    // op: 0 I/O write, 1 I/O read, 2 memory write, 3 memory read
    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 16'h0000, 8'h15, 8'h00, 4'd8},
        '{2'd1, 16'h0000, 8'h00, 8'h15, 4'd8},  // R8
        '{2'd2, 16'h0010, 8'hAB, 8'h00, 4'd5},
        '{2'd0, 16'h0000, 8'h03, 8'h00, 4'd8},
        '{2'd3, 16'h0010, 8'h00, 8'hAB, 4'd6},  // R6
        '{2'd1, 16'h0000, 8'h00, 8'h15, 4'd6},  // R6 attribute loaded
        '{2'd0, 16'h0000, 8'h8A, 8'h00, 4'd8},
        '{2'd1, 16'h0000, 8'h00, 8'h8A, 4'd8},
        '{2'd3, 16'h0010, 8'h00, 8'hAB, 4'd7},  // R7
        '{2'd1, 16'h0000, 8'h00, 8'h8A, 4'd7},  // R7 held
        '{2'd0, 16'h0000, 8'hFF, 8'h00, 4'd8},
        '{2'd1, 16'h0000, 8'h00, 8'h9F, 4'd8},  // R8 bits 6:5 zero
        '{2'd0, 16'h0000, 8'h07, 8'h00, 4'd9},
        '{2'd2, 16'h4010, 8'h55, 8'h00, 4'd9},
        '{2'd3, 16'h4010, 8'h00, 8'h55, 4'd9},  // R9
        '{2'd1, 16'h0000, 8'h00, 8'h07, 4'd9},  // R9 register untouched
        '{2'd3, 16'h0010, 8'h00, 8'h55, 4'd9},
        '{2'd1, 16'h0000, 8'h00, 8'h15, 4'd9}   // R9 attribute cell intact
    };

    task automatic check(input int rq, input logic [7:0] got, input logic [7:0] exp,
                         input string what);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d %s: got %h expected %h", rq, what, got, exp);
        end
    endtask

    task automatic cpu_op(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!cpu_slot) @(negedge clk);
        cpu_io = (op < 2); cpu_wr = (op == 0 || op == 2); cpu_rd = (op == 1 || op == 3);
        cpu_addr = a; cpu_wdata = d;
        #1;
        s_mem_we = mem_we; s_atr_we = atr_we; s_atr_wdata = atr_wdata;
        @(negedge clk);
        cpu_io = 0; cpu_wr = 0; cpu_rd = 0;
    endtask

    task automatic video_at(input logic [15:0] a);
        @(negedge clk);
        while (cpu_slot) @(negedge clk);
        vid_addr = a;
        @(negedge clk);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mmem[i] = 8'(i) ^ 8'h5A;
            amem[i] = 5'(i);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(1, {7'd0, cpu_slot}, 8'd0, "slot after reset");
        check(1, {7'd0, vid_valid}, 8'd0, "vid_valid after reset");
        check(1, {6'd0, mem_we, atr_we}, 8'd0, "strobes after reset");
        cpu_op(2'd1, 16'h0, 8'h0);
        check(1, cpu_rdata, 8'h00, "register after reset");

        for (int k = 0; k < NV; k++) begin
            cpu_op(VEC[k].op, VEC[k].addr, VEC[k].wd);
            if (VEC[k].op[0]) check(int'(VEC[k].rq), cpu_rdata, VEC[k].exp, $sformatf("vec %0d", k));
        end

        // R5 paired write carries register attribute
        cpu_op(2'd0, 16'h0, 8'h0C);
        check(10, {6'd0, s_mem_we, s_atr_we}, 8'd0, "I/O write strobes (R10)");
        cpu_op(2'd2, 16'h0030, 8'h66);
        check(5, {6'd0, s_mem_we, s_atr_we}, 8'h03, "write strobes");
        check(5, {3'd0, s_atr_wdata}, 8'h0C, "attribute write data");
        cpu_op(2'd1, 16'h0, 8'h0);
        check(10, {6'd0, s_mem_we, s_atr_we}, 8'd0, "I/O read strobes (R10)");

        // R2 write strobe during the video slot is ignored
        @(negedge clk);
        while (cpu_slot) @(negedge clk);
        cpu_wr = 1; cpu_addr = 16'h0020; cpu_wdata = 8'h77;
        #1;
        check(2, {6'd0, mem_we, atr_we}, 8'd0, "strobes in video slot");
        check(2, {7'd0, cpu_slot}, 8'd0, "slot low");
        @(negedge clk);
        check(2, {7'd0, cpu_slot}, 8'd1, "slot toggled");
        cpu_wr = 0;
        cpu_op(2'd3, 16'h0020, 8'h0);
        check(2, cpu_rdata, 8'h7A, "memory unchanged by video-slot strobe");

        // R3 video fetch inside window
        video_at(16'h0030);
        check(3, {7'd0, vid_valid}, 8'd1, "vid_valid pulse");
        check(3, vid_data, 8'h66, "video data");
        check(3, {3'd0, vid_attr}, 8'h0C, "video attribute");
        @(negedge clk);
        check(3, {7'd0, vid_valid}, 8'd0, "vid_valid one clock");
        // R4 video fetch outside window
        video_at(16'h4044);
        check(4, vid_data, 8'h44 ^ 8'h5A, "video data outside");
        check(4, {3'd0, vid_attr}, 8'h00, "video attribute outside");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule